// File: doc/BRIEF.md
# Divided Countdown Timer

This block is an interrupt countdown timer. It sits next to an interrupt priority unit. Software sets a clock prescaler through a 4-bit divide configuration and loads a start value. It then sets up a single timer entry, which holds an interrupt vector, a mask bit, a delivery-status bit and a periodic-mode bit. The counter steps down once per prescaled tick and can be read at any time. When it expires, the block records a pending expiry. A pending expiry becomes a one-cycle interrupt request carrying the entry's vector, but only while the global software enable is high and the entry is unmasked.

In one-shot mode the counter halts at zero after it expires. In periodic mode it reloads the start value and keeps running. A start value of zero stops the timer. Expiries that arrive while the entry is masked are held in a small saturating count. Each held expiry is delivered on its own cycle once the entry is unmasked. Dropping the software enable forces the entry masked and discards every held expiry.

Top module: `divtimer`

## Requirements
- R1: After reset the entry reads 0x200 (mask set, all else zero), the divide configuration and current count read 0, and no request is raised.
- R2: The divide code is {cfg[3], cfg[1], cfg[0]} and the ratio is 2 raised to ((code+1) mod 8), so code 7 gives 1 and code 0 gives 2. Bit 2 is stored and read back but has no effect on the ratio. The first expiry comes exactly start value × ratio clocks after the start write.
- R3: The current count reads 0 while the start value is 0. Otherwise it reads the start value right after the write and then drops by one per prescaled tick.
- R4: A start write restarts the count and the prescaler from the new value and discards held expiries. Writing 0 stops the timer, so no expiry follows.
- R5: The entry's periodic bit is bit 10. With it set, the counter reloads the start value on expiry and expires again every start value × ratio clocks. With it clear, the counter stays at 0 and expires once.
- R6: The request is high only while the enable is high, the entry's mask bit (bit 9) is clear and an expiry is held. irq_vec then carries entry bits 7:0, and one held expiry is consumed per request cycle.
- R7: Expiries that occur while the entry is masked are held, up to the limit of the hold counter. Unmasking delivers them as that many consecutive request cycles.
- R8: While the enable is low, the entry's mask bit is forced to 1, including on writes made in that cycle, and all held expiries are discarded.
- R9: The entry keeps exactly bits 10:0: vector 7:0, delivery status 8, mask 9 and periodic 10. All of these read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Global software enable |
| cfg_we | input | 1 | Divide configuration write strobe |
| cfg_wdata | input | 4 | Divide configuration value |
| init_we | input | 1 | Start value write strobe |
| init_wdata | input | CNT_W | Start value |
| ent_we | input | 1 | Timer entry write strobe |
| ent_wdata | input | VEC_W+3 | Timer entry value |
| cfg_rdata | output | 4 | Stored divide configuration |
| ent_rdata | output | VEC_W+3 | Stored timer entry |
| cur_count | output | CNT_W | Current count |
| irq_req | output | 1 | Interrupt request, one cycle per delivered expiry |
| irq_vec | output | VEC_W | Vector delivered with the request |

## Verification
A prescaler or ratio decode error shows up as an expiry that is early or late by a whole multiple of clocks. That error is visible on irq_req as soon as the first period ends. A counter that fails to reload or fails to stop appears as a missing or extra request within one more period. A hold count that is wrong shows at unmasking, where it gives the wrong number of back-to-back request cycles. A forced mask that fails to take effect is visible on ent_rdata one cycle after the enable drops.

// File: rtl/divtimer.sv
`timescale 1ns/1ps
module divtimer #(
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_en,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_wdata,
  input  logic             init_we,
  input  logic [CNT_W-1:0] init_wdata,
  input  logic             ent_we,
  input  logic [VEC_W+2:0] ent_wdata,
  output logic [3:0]       cfg_rdata,
  output logic [VEC_W+2:0] ent_rdata,
  output logic [CNT_W-1:0] cur_count,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int MASK_B = VEC_W + 1;
  localparam int PER_B  = VEC_W + 2;
  localparam int ENT_W  = VEC_W + 3;
  localparam int PRE_W  = 8;

  logic [3:0]        cfg_q;
  logic [CNT_W-1:0]  init_q, cnt_q;
  logic [PRE_W-1:0]  pre_q, last_pre;
  logic [ENT_W-1:0]  ent_q, ent_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [2:0]        shift;
  logic              tick, expire;

  assign shift    = {cfg_q[3], cfg_q[1], cfg_q[0]} + 3'd1;
  assign last_pre = (PRE_W'(1) << shift) - PRE_W'(1);
  assign tick     = (cnt_q != '0) && (pre_q >= last_pre);
  assign expire   = tick && (cnt_q == CNT_W'(1));

  assign irq_req   = sw_en && !ent_q[MASK_B] && (pend_q != '0);
  assign irq_vec   = ent_q[VEC_W-1:0];
  assign ent_rdata = ent_q;
  assign cfg_rdata = cfg_q;
  assign cur_count = (init_q == '0) ? '0 : cnt_q;

  always_comb begin
    ent_d = ent_we ? ent_wdata : ent_q;
    if (!sw_en) ent_d[MASK_B] = 1'b1;
  end

  always_comb begin
    pend_d = pend_q;
    if (expire && pend_q != '1) pend_d = pend_d + PEND_W'(1);
    if (irq_req)                pend_d = pend_d - PEND_W'(1);
    if (!sw_en || init_we)      pend_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      init_q <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      ent_q  <= ENT_W'(1) << MASK_B;
      pend_q <= '0;
    end else begin
      ent_q  <= ent_d;
      pend_q <= pend_d;
      if (cfg_we) cfg_q <= cfg_wdata;
      if (init_we) begin
        init_q <= init_wdata;
        cnt_q  <= init_wdata;
        pre_q  <= '0;
      end else if (tick) begin
        pre_q <= '0;
        if (expire) cnt_q <= ent_q[PER_B] ? init_q : '0;
        else        cnt_q <= cnt_q - CNT_W'(1);
      end else if (cnt_q != '0) begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

module divtimer_chk #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_en,
  input logic             init_we,
  input logic [CNT_W-1:0] init_wdata,
  input logic [VEC_W+2:0] ent_rdata,
  input logic [CNT_W-1:0] cur_count,
  input logic             irq_req
);
  localparam int MASK_B = VEC_W + 1;

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (sw_en && !ent_rdata[MASK_B])); // R6
  AST_OFF_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> ent_rdata[MASK_B]); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !irq_req); // R8
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    init_we |=> (cur_count == $past(init_wdata))); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(init_we) && cur_count != $past(cur_count)) |->
      (cur_count == $past(cur_count) - CNT_W'(1) || $past(cur_count) == CNT_W'(1))); // R3
endmodule

bind divtimer divtimer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .init_we(init_we),
  .init_wdata(init_wdata), .ent_rdata(ent_rdata), .cur_count(cur_count),
  .irq_req(irq_req)
);

// File: tb/divtimer_tb_top.sv
`timescale 1ns/1ps
module divtimer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, sw_en = 1'b1;
  logic        cfg_we = 1'b0, init_we = 1'b0, ent_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic [31:0] init_wdata = '0;
  logic [10:0] ent_wdata = '0;
  logic [3:0]  cfg_rdata;
  logic [10:0] ent_rdata;
  logic [31:0] cur_count;
  logic        irq_req;
  logic [7:0]  irq_vec;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divtimer dut_i (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .init_we(init_we), .init_wdata(init_wdata), .ent_we(ent_we), .ent_wdata(ent_wdata),
    .cfg_rdata(cfg_rdata), .ent_rdata(ent_rdata), .cur_count(cur_count),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  localparam logic [3:0] T_CFG [6] = '{4'hB, 4'h0, 4'h1, 4'h8, 4'hA, 4'h7};
  localparam int         T_N   [6] = '{5, 3, 2, 2, 1, 3};
  localparam logic [7:0] T_VEC [6] = '{8'h31, 8'h42, 8'h53, 8'h64, 8'h75, 8'h86};
  localparam int         T_CYC [6] = '{5, 6, 8, 64, 128, 48};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v; @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic wr_ent(input logic [10:0] v);
    ent_we = 1'b1; ent_wdata = v; @(negedge clk); ent_we = 1'b0;
  endtask
  task automatic start(input logic [31:0] v);
    init_we = 1'b1; init_wdata = v; @(negedge clk); init_we = 1'b0;
  endtask
  task automatic wait_irq(output int n);
    n = 1;
    while (!irq_req && n < 1000) begin @(negedge clk); n++; end
  endtask
  task automatic count_irq(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      if (irq_req) hits++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ent_rdata == 11'h200, "R1 entry", ent_rdata, 11'h200);
    chk(cfg_rdata == 4'h0 && cur_count == 0, "R1 cfg/count", cur_count, 0);
    chk(!irq_req, "R1 irq", irq_req, 0);

    wr_ent(11'h7FF);
    chk(ent_rdata == 11'h7FF, "R9 readback", ent_rdata, 11'h7FF);
    wr_cfg(4'h7);
    chk(cfg_rdata == 4'h7, "R2 cfg readback", cfg_rdata, 4'h7);

    for (int i = 0; i < 6; i++) begin
      wr_cfg(T_CFG[i]);
      wr_ent({3'b000, T_VEC[i]});
      start(T_N[i]);
      wait_irq(n);
      chk(n == T_CYC[i] + 1, "R2 period", n - 1, T_CYC[i]);
      chk(irq_vec == T_VEC[i], "R6 vector", irq_vec, T_VEC[i]);
      @(negedge clk);
      chk(!irq_req, "R6 single pulse", irq_req, 0);
    end

    wr_cfg(4'hB);
    start(0);
    chk(cur_count == 0, "R3 zero start", cur_count, 0);
    start(10);
    chk(cur_count == 10, "R3 load", cur_count, 10);
    repeat (4) @(negedge clk);
    chk(cur_count == 6, "R3 step", cur_count, 6);
    start(4);
    chk(cur_count == 4, "R4 restart load", cur_count, 4);
    wait_irq(n);
    chk(n == 5, "R4 restart period", n - 1, 4);
    @(negedge clk);
    start(5);
    start(0);
    count_irq(20, h);
    chk(h == 0, "R4 stop", h, 0);
    chk(cur_count == 0, "R4 stopped count", cur_count, 0);

    wr_ent(11'h455);
    start(3);
    wait_irq(n);
    chk(n == 4, "R5 first period", n - 1, 3);
    chk(cur_count == 3, "R5 reload", cur_count, 3);
    @(negedge clk);
    wait_irq(n);
    chk(n == 3, "R5 second period", n, 3);
    start(0);
    wr_ent(11'h056);
    start(2);
    count_irq(15, h);
    chk(h == 1, "R5 one-shot once", h, 1);
    chk(cur_count == 0, "R5 one-shot holds zero", cur_count, 0);

    wr_ent(11'h600);
    start(2);
    h = 0;
    for (int i = 0; i < 6; i++) begin if (irq_req) h++; @(negedge clk); end
    chk(h == 0, "R7 masked quiet", h, 0);
    wr_ent(11'h200);
    wr_ent(11'h0AB);
    chk(irq_req, "R7 held delivered", irq_req, 1);
    h = 0;
    for (int i = 0; i < 10; i++) begin
      if (irq_req) begin h++; chk(irq_vec == 8'hAB, "R7 vector", irq_vec, 8'hAB); end
      @(negedge clk);
    end
    chk(h == 4, "R7 held count", h, 4);

    wr_ent(11'h200);
    start(1);
    @(negedge clk);
    sw_en = 1'b0; ent_we = 1'b1; ent_wdata = 11'h0CD;
    @(negedge clk);
    sw_en = 1'b1; ent_we = 1'b0;
    chk(ent_rdata == 11'h2CD, "R8 write forced masked", ent_rdata, 11'h2CD);
    wr_ent(11'h0CD);
    count_irq(6, h);
    chk(h == 0, "R8 held dropped", h, 0);
    sw_en = 1'b0;
    @(negedge clk);
    chk(ent_rdata[9], "R8 existing masked", ent_rdata, 11'h2CD);
    sw_en = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule